// File: doc/BRIEF.md
# FM Clock/Data Pulse Separator

This block splits the combined read-pulse stream of a single-density (FM) floppy drive into two pulse streams: one carrying the clock pulses and one carrying the data-1 pulses. It behaves like a one-shot timing window that cannot be retriggered. A raw pulse that ends while the window is closed is taken as a clock pulse. That pulse is sent to the clock output and opens a window of `win_len` system clock cycles. A raw pulse that ends while the window is open is taken as a data 1 and sent to the data output. A data pulse never restarts or extends the window.

The raw input is asynchronous. It is passed through a two-flop synchroniser, and its trailing (falling) edge is what gets classified. Each classified pulse produces a registered output pulse of `PULSE_CYC` cycles. The first cycle of that pulse comes three system clock edges after the raw pulse falls. A window-active output shows the state of the one-shot.

The separator only suits FM recording, where every bitcell carries a clock pulse. When a clock bit is missing, as in a sync mark, it loses phase: data pulses are then taken as clocks. It stays out of phase until a data-0 cell lets a real clock pulse fall outside a window again. The block shows this behaviour as it is and does not mask it. Typical window settings are 2.8 µs for 8-inch drives and about 6 µs for 5¼-inch drives, each converted to system clock cycles.

Top module: `fm_pulse_splitter`

## Requirements
- R1: A raw pulse whose falling edge is classified while `win_on` is low pulses `sep_clk` and opens a new window.
- R2: A raw pulse whose falling edge is classified while `win_on` is high pulses `sep_dat`. It does not reload, extend or restart the window.
- R3: The window lasts exactly `win_len` cycles. Measured between raw falling edges, a second pulse `win_len` cycles after a clock pulse is data, and one `win_len`+1 cycles after it is clock.
- R4: The window is timed from the trailing (falling) edge of the triggering raw pulse, whatever the width of that pulse.
- R5: Each output pulse is high for exactly `PULSE_CYC` cycles (default 4). It rises on the third rising clock edge after the raw input falls. `sep_clk` and `sep_dat` are never high in the same cycle.
- R6: When `win_len` is zero, no window opens and every raw pulse goes out on `sep_clk`.
- R7: After a missing clock bit, the next data 1 is classed as clock. The separator stays out of phase, swapping clock and data, until a data-0 cell lets a true clock pulse fall outside a window.
- R8: After reset, and on the cycle after `enable` is low, `sep_clk`, `sep_dat` and `win_on` are all 0. Raw pulses that fall while `enable` is low produce no output and open no window.
- R9: `win_on` is high for exactly `win_len` cycles. Its first cycle is the first cycle of the `sep_clk` pulse that opened the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_raw | input | 1 | Asynchronous combined read pulses, active high |
| win_len | input | WIN_W | Window length in system clock cycles; 0 disables data classification |
| enable | input | 1 | Separation enable; low clears the window and the outputs |
| sep_clk | output | 1 | Separated clock pulse |
| sep_dat | output | 1 | Separated data pulse |
| win_on | output | 1 | One-shot window currently open |

## Verification
An FM stream with a 40-cycle bitcell and a 28-cycle window is driven as all ones, all zeros, and a mark with a missing clock bit. All ones shows that clock and data alternate correctly. All zeros shows that a clock pulse falling after the window has closed is still a clock. The missing-clock mark shows the swap of clock and data and the recovery on the next data-0 cell. Directed cases cover the following:
- Pulses one cycle either side of the window edge, which pin down the window length.
- A data pulse followed by a late pulse, which would be classed as data if a data pulse restarted the window.
- A wide trigger pulse, which tells trailing-edge timing apart from leading-edge timing.
- A zero window length.
- A disabled block.

// File: rtl/fm_pulse_splitter.sv
module fm_pulse_splitter #(
  parameter int WIN_W     = 12,
  parameter int PULSE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_raw,
  input  logic [WIN_W-1:0] win_len,
  input  logic             enable,
  output logic             sep_clk,
  output logic             sep_dat,
  output logic             win_on
);

  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam logic [PW-1:0] PLOAD = PW'(PULSE_CYC);

  logic [2:0]       sync_q;
  logic [WIN_W-1:0] win_cnt;
  logic [PW-1:0]    clk_cnt, dat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], rd_raw};
  end

  wire trail  = enable & sync_q[2] & ~sync_q[1];
  wire as_clk = trail & (win_cnt == '0);
  wire as_dat = trail & (win_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable)    win_cnt <= '0;
    else if (as_clk)          win_cnt <= win_len;
    else if (win_cnt != '0)   win_cnt <= win_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable)    clk_cnt <= '0;
    else if (as_clk)          clk_cnt <= PLOAD;
    else if (as_dat)          clk_cnt <= '0;
    else if (clk_cnt != '0)   clk_cnt <= clk_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable)    dat_cnt <= '0;
    else if (as_dat)          dat_cnt <= PLOAD;
    else if (as_clk)          dat_cnt <= '0;
    else if (dat_cnt != '0)   dat_cnt <= dat_cnt - 1'b1;
  end

  assign sep_clk = clk_cnt != '0;
  assign sep_dat = dat_cnt != '0;
  assign win_on  = win_cnt != '0;

  // R5
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sep_clk && sep_dat));

  // R8
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sep_clk && !sep_dat && !win_on));

  // R2
  win_noreload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && win_on && !as_clk) |=> (win_cnt == $past(win_cnt) - 1'b1));

  // R1
  clk_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sep_clk) |-> (win_cnt == $past(win_len)));

  // R9
  win_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_on) |-> $rose(sep_clk));

endmodule

// File: tb/test_fm_pulse_splitter.sv
module test_fm_pulse_splitter;
  logic clk = 0, rst_n = 0, rd_raw = 0, enable = 0;
  logic [11:0] win_len = 12'd28;
  logic sep_clk, sep_dat, win_on;
  int total = 0, bad = 0, since = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fm_pulse_splitter #(.WIN_W(12), .PULSE_CYC(4)) i_fm_pulse_splitter (
    .clk(clk), .rst_n(rst_n), .rd_raw(rd_raw), .win_len(win_len),
    .enable(enable), .sep_clk(sep_clk), .sep_dat(sep_dat), .win_on(win_on));

  // {kind (0 clock, 1 data), gap in cycles between raw falling edges}
  localparam int NV = 23;
  localparam logic [8:0] VEC [NV] = '{
    {1'b0, 8'd100}, {1'b1, 8'd20}, {1'b0, 8'd20}, {1'b1, 8'd20},
    {1'b0, 8'd20},  {1'b1, 8'd20}, {1'b0, 8'd20},
    {1'b0, 8'd40},  {1'b0, 8'd40}, {1'b0, 8'd40},
    {1'b0, 8'd60},  {1'b1, 8'd20}, {1'b0, 8'd20}, {1'b1, 8'd20},
    {1'b0, 8'd40},  {1'b1, 8'd20}, {1'b0, 8'd20},
    {1'b1, 8'd20},  {1'b0, 8'd10},
    {1'b0, 8'd29},  {1'b1, 8'd28},
    {1'b0, 8'd40},  {1'b0, 8'd40}
  };

  task automatic tick();
    @(negedge clk);
    since++;
  endtask

  task automatic fire(int gap, int hi);
    repeat (gap - hi - since) @(negedge clk);
    rd_raw = 1;
    repeat (hi) @(negedge clk);
    rd_raw = 0;
    since = 0;
  endtask

  task automatic check(string req, logic got_c, logic got_d, logic exp_c, logic exp_d);
    total++;
    if (got_c !== exp_c || got_d !== exp_d) begin
      bad++;
      $display("FAIL %s: clk/dat=%b%b expected %b%b", req, got_c, got_d, exp_c, exp_d);
    end
  endtask

  task automatic classify(string req, bit kind);
    repeat (3) tick();
    check(req, sep_clk, sep_dat, !kind, kind);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 reset", sep_clk, sep_dat, 0, 0);
    check("R8 reset win", win_on, 0, 0, 0);
    rst_n = 1; enable = 1;
    repeat (5) @(negedge clk);

    // R1 R2 R3 R7: table of FM patterns
    for (int i = 0; i < NV; i++) begin
      fire(int'(VEC[i][7:0]), 2);
      classify($sformatf("R1/R2/R3/R7 vec%0d", i), VEC[i][8]);
    end

    // R4 wide trigger, next fall 25 after its trailing edge
    fire(100, 20); classify("R4 wide clock", 0);
    fire(25, 2);   classify("R4 trailing-edge data", 1);

    // R5 width
    begin
      int hc = 0, hd = 0;
      fire(100, 2);
      for (int k = 0; k < 8; k++) begin
        tick();
        if (sep_clk) hc++;
        if (sep_dat) hd++;
      end
      check("R5 clock width", hc == 4, hd == 0, 1, 1);
    end

    // R9 window duration (win_len 28): high at fall+30, low at fall+31
    fire(100, 2);
    repeat (30) tick();
    check("R9 window open", win_on, 0, 1, 0);
    tick();
    check("R9 window closed", win_on, 0, 0, 0);

    // R6 zero window
    win_len = 0;
    fire(100, 2); classify("R6 zero win a", 0);
    check("R6 no window", win_on, 0, 0, 0);
    fire(20, 2);  classify("R6 zero win b", 0);
    fire(10, 2);  classify("R6 zero win c", 0);
    win_len = 12'd28;

    // R8 disabled
    enable = 0;
    fire(100, 2);
    repeat (3) tick();
    check("R8 disabled out", sep_clk, sep_dat, 0, 0);
    check("R8 disabled win", win_on, 0, 0, 0);
    enable = 1;
    fire(20, 2); classify("R8 no window after disable", 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule